// File: doc/BRIEF.md
# Three-Phase Serial Exchange Master

This block runs one complete exchange with a slave microcontroller over a three-wire serial link made of a serial clock, an outgoing data line and an incoming data line, plus an active-low select. A start strobe latches an operand word. The master then shifts the operand out and gives the slave a fixed run of idle clock pulses to compute in. After that it clocks the result word back in. All three phases are sequenced by one state machine, so the serial clock toggles on every system cycle from the first pulse to the last. No dead cycle falls between the phases.

The serial clock is not a separate clock. It is a register that toggles inside the system clock domain, so one serial bit lasts two system cycles and a 40 MHz system clock yields a 20 MHz link. Operand and result both travel most significant bit first. The slave samples the outgoing line on the rising serial edge. The master samples the incoming line on the same system edge that raises the serial clock.

Top module: `serial_xchg_master`

## Requirements
- R1: While reset is asserted, and after it is released with no start, busy_o, done_o, sclk_o and mosi_o are 0, sel_n_o is 1 and result_o is 0.
- R2: The write phase sends the latched operand as WR_BITS pulses, most significant bit first. Pulse n carries bit WR_BITS-1-n. Each bit is on mosi_o one system cycle before its rising serial edge and does not change on that edge.
- R3: After the last write pulse come exactly PROC_CLKS serial pulses with mosi_o held at 0. mosi_o is also 0 whenever busy_o is 0.
- R4: After the processing pulses come exactly RD_BITS pulses. miso_i is sampled on the system edge that raises sclk_o, and the first sample becomes result bit RD_BITS-1.
- R5: sclk_o toggles on every system cycle while busy_o stays high. It rises on the first cycle after start is accepted. A transaction keeps busy_o high for exactly 2*(WR_BITS+PROC_CLKS+RD_BITS) system cycles (80 at defaults).
- R6: done_o is high for exactly one cycle. That cycle is the one in which sclk_o is high for the last read pulse. result_o takes its new value in that same cycle and holds it at all other times.
- R7: start_i is accepted only when busy_o is 0, and the operand is latched at acceptance. A start_i pulse during a transaction changes neither timing, outgoing data nor result. Holding start_i high starts a new transaction on the first cycle busy_o is 0.
- R8: The serial clock idles low. sel_n_o is 0 exactly while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a transaction (sampled when idle) |
| operand_i | input | WR_BITS | Word to send, latched on acceptance |
| result_o | output | RD_BITS | Last word received |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to slave |
| miso_i | input | 1 | Serial data from slave |
| sel_n_o | output | 1 | Active-low slave select |

## Verification
The bench builds the block with its default widths: a 16-bit operand, 8 processing pulses and a 16-bit result. At those values the 80-cycle transaction is short enough to compare every cycle of several complete exchanges against a reference built on a transaction-cycle index. This covers the two phase boundaries inside a transaction and the restart that follows at once when start is held high. The slave model drives filler data on the incoming line outside the sampling windows, so a capture on the wrong edge or in the wrong phase shows up in the result.

// File: rtl/sxm_pkg.sv
package sxm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_PROC  = 2'd2,
        PH_READ  = 2'd3
    } phase_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sxm_sclk_gen.sv
// Serial clock as a toggling register in the system domain.
// rise_due_o / fall_due_o tell the sequencer which serial edge the
// coming system edge will produce.
module sxm_sclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_due_o,
    output logic fall_due_o
);

    logic sclk_d, sclk_q;

    always_comb begin
        sclk_d     = run_i ? ~sclk_q : 1'b0;
        rise_due_o = run_i & ~sclk_q;
        fall_due_o = run_i &  sclk_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end

    assign sclk_o = sclk_q;

endmodule

// File: rtl/sxm_tx_shift.sv
// Outgoing shift register, MSB first; advances on falling serial edges.
module sxm_tx_shift #(
    parameter int unsigned WR_BITS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [WR_BITS-1:0] data_i,
    input  logic               advance_i,
    input  logic               drive_i,
    output logic               mosi_o
);

    logic [WR_BITS-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i)         sr_d = data_i;
        else if (advance_i) sr_d = sr_q << 1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign mosi_o = drive_i & sr_q[WR_BITS-1];

endmodule

// File: rtl/sxm_rx_shift.sv
// Incoming shift register; the final sample goes straight into the
// result register together with the completion pulse.
module sxm_rx_shift #(
    parameter int unsigned RD_BITS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_i,
    input  logic               last_i,
    input  logic               miso_i,
    output logic [RD_BITS-1:0] result_o,
    output logic               done_o
);

    typedef struct packed {
        logic [RD_BITS-2:0] sr;
        logic [RD_BITS-1:0] result;
        logic               done;
    } rx_t;

    rx_t                cur_q, nxt_d;
    logic [RD_BITS-1:0] full;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        full       = {cur_q.sr, miso_i};
        if (sample_i) begin
            nxt_d.sr = full[RD_BITS-2:0];
            if (last_i) begin
                nxt_d.result = full;
                nxt_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign result_o = cur_q.result;
    assign done_o   = cur_q.done;

endmodule

// File: rtl/serial_xchg_master.sv
// One sequencer drives write, processing and read phases back to back.
module serial_xchg_master #(
    parameter int unsigned WR_BITS   = 16,
    parameter int unsigned PROC_CLKS = 8,
    parameter int unsigned RD_BITS   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WR_BITS-1:0] operand_i,
    output logic [RD_BITS-1:0] result_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               sclk_o,
    output logic               mosi_o,
    input  logic               miso_i,
    output logic               sel_n_o
);
    import sxm_pkg::*;

    localparam int unsigned CNT_MAX = max3(WR_BITS, PROC_CLKS, RD_BITS);
    localparam int unsigned CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_BITS - 1);
    localparam logic [CNT_W-1:0] PC_LAST = CNT_W'(PROC_CLKS - 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_BITS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic run, rise_due, fall_due;
    logic load, advance, sample, last_rd;

    always_comb begin
        nxt_d   = cur_q;
        run     = (cur_q.phase != PH_IDLE);
        load    = (cur_q.phase == PH_IDLE) && start_i;
        advance = (cur_q.phase == PH_WRITE) && fall_due;
        sample  = (cur_q.phase == PH_READ) && rise_due;
        last_rd = (cur_q.cnt == RD_LAST);
        unique case (cur_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    nxt_d.phase = PH_WRITE;
                    nxt_d.cnt   = '0;
                end
            end
            PH_WRITE: begin
                if (fall_due) begin
                    if (cur_q.cnt == WR_LAST) begin
                        nxt_d.phase = PH_PROC;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            PH_PROC: begin
                if (fall_due) begin
                    if (cur_q.cnt == PC_LAST) begin
                        nxt_d.phase = PH_READ;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            PH_READ: begin
                if (fall_due) begin
                    if (last_rd) begin
                        nxt_d.phase = PH_IDLE;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            default: nxt_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{phase: PH_IDLE, cnt: '0};
        else        cur_q <= nxt_d;
    end

    sxm_sclk_gen u_sclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .sclk_o     (sclk_o),
        .rise_due_o (rise_due),
        .fall_due_o (fall_due)
    );

    sxm_tx_shift #(.WR_BITS(WR_BITS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .data_i    (operand_i),
        .advance_i (advance),
        .drive_i   (cur_q.phase == PH_WRITE),
        .mosi_o    (mosi_o)
    );

    sxm_rx_shift #(.RD_BITS(RD_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .last_i   (last_rd),
        .miso_i   (miso_i),
        .result_o (result_o),
        .done_o   (done_o)
    );

    assign busy_o  = run;
    assign sel_n_o = ~run;

endmodule

// File: rtl/serial_xchg_master_chk.sv
module serial_xchg_master_chk #(
    parameter int unsigned WR_BITS   = 16,
    parameter int unsigned PROC_CLKS = 8,
    parameter int unsigned RD_BITS   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [RD_BITS-1:0] result_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               sclk_o,
    input logic               mosi_o,
    input logic               sel_n_o
);
    localparam int unsigned LEN   = 2 * (WR_BITS + PROC_CLKS + RD_BITS);
    localparam int unsigned LEN_W = $clog2(LEN + 1) + 1;

    logic [LEN_W-1:0] busy_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      busy_len_q <= '0;
        else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
        else             busy_len_q <= '0;
    end

    assert_idle_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && sel_n_o));

    assert_active_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !sel_n_o);

    assert_bit_stable_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(mosi_o));

    assert_mosi_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mosi_o);

    assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (sclk_o != $past(sclk_o)));

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len_q == LEN_W'(LEN)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_on_high_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && sclk_o));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    assert_start_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

endmodule

bind serial_xchg_master serial_xchg_master_chk #(
    .WR_BITS  (WR_BITS),
    .PROC_CLKS(PROC_CLKS),
    .RD_BITS  (RD_BITS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .result_o (result_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .sel_n_o  (sel_n_o)
);

// File: tb/serial_xchg_master_tb_top.sv
`timescale 1ns/1ps
module serial_xchg_master_tb_top;
    localparam int WB  = 16;
    localparam int PC  = 8;
    localparam int RB  = 16;
    localparam int LEN = 2 * (WB + PC + RB);
    localparam int RD0 = 2 * (WB + PC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [WB-1:0] operand_i = '0;
    logic [RB-1:0] result_o;
    logic          busy_o, done_o, sclk_o, mosi_o, sel_n_o;
    logic          miso_i = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state
    bit            m_active = 0;
    int            m_k = 0;
    logic [WB-1:0] m_op = '0;
    logic [RB-1:0] m_acc = '0;
    logic [RB-1:0] m_res = '0;
    bit            m_done = 0;
    logic [RB-1:0] resp = '0;
    int            cyc = 0;

    always #5 clk = ~clk;

    serial_xchg_master #(.WR_BITS(WB), .PROC_CLKS(PC), .RD_BITS(RB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .result_o(result_o), .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .sel_n_o(sel_n_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    function automatic logic exp_mosi();
        if (m_active && m_k < 2 * WB) return m_op[WB - 1 - m_k / 2];
        return 1'b0;
    endfunction

    // model update and per-cycle comparison
    always @(posedge clk) begin
        cyc++;
        m_done = 0;
        if (!rst_n) begin
            m_active = 0; m_k = 0; m_res = '0; m_acc = '0;
        end else if (m_active) begin
            m_k++;
            if ((m_k % 2 == 1) && m_k > RD0) m_acc = {m_acc[RB-2:0], miso_i};
            if (m_k == LEN - 1) begin m_res = m_acc; m_done = 1; end
            if (m_k == LEN) m_active = 0;
        end else if (start_i) begin
            m_active = 1; m_k = 0; m_op = operand_i;
        end
        #2;
        if (rst_n) begin
            check(busy_o == m_active, "R5 busy", 32'(busy_o), 32'(m_active));
            check(sclk_o == (m_active && (m_k % 2 == 1)), "R5 sclk",
                  32'(sclk_o), 32'(m_active && (m_k % 2 == 1)));
            if (m_active && m_k < 2 * WB)
                check(mosi_o == exp_mosi(), "R2 mosi", 32'(mosi_o), 32'(exp_mosi()));
            else
                check(mosi_o == 1'b0, "R3 mosi low", 32'(mosi_o), 32'd0);
            check(sel_n_o == !m_active, "R8 select", 32'(sel_n_o), 32'(!m_active));
            check(done_o == m_done, "R6 done", 32'(done_o), 32'(m_done));
            check(result_o == m_res, "R6 result", 32'(result_o), 32'(m_res));
        end
    end

    // slave model: valid result bit around each read rising edge, filler elsewhere
    always @(negedge clk) begin
        if (m_active && m_k >= RD0 && m_k < LEN)
            miso_i <= resp[RB - 1 - (m_k - RD0) / 2];
        else
            miso_i <= cyc[1] ^ cyc[3];
    end

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 4 * LEN; i++) begin
            @(posedge clk); #3;
            if (done_o) begin seen = 1; break; end
        end
    endtask

    task automatic run_xfer(input logic [WB-1:0] op, input logic [RB-1:0] rsp,
                            input bit poke_mid);
        bit seen;
        resp = rsp;
        @(negedge clk); start_i = 1'b1; operand_i = op;
        @(negedge clk); start_i = 1'b0; operand_i = ~op;
        if (poke_mid) begin
            // R7: strobes during write and read phases must be ignored
            repeat (10) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            repeat (45) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        wait_done(seen);
        check(seen, "R6 done seen", 32'(seen), 32'd1);
        check(result_o == rsp, "R4 result word", 32'(result_o), 32'(rsp));
        if (poke_mid) check(result_o == rsp, "R7 mid strobe ignored", 32'(result_o), 32'(rsp));
        repeat (4) @(negedge clk);
        check(busy_o == 1'b0, "R7 idle after single transaction", 32'(busy_o), 32'd0);
    endtask

    initial begin
        #(2_000_000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (4) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && sclk_o == 0 && mosi_o == 0, "R1 outputs in reset",
              {busy_o, done_o, sclk_o, mosi_o}, 32'd0);
        check(sel_n_o == 1 && result_o == 0, "R1 select/result in reset",
              {sel_n_o, result_o}, 32'h10000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy_o == 0 && sclk_o == 0 && sel_n_o == 1, "R1 idle after reset",
              {busy_o, sclk_o, sel_n_o}, 32'd1);

        run_xfer(16'hA5C3, 16'h3C5A, 1'b0);
        run_xfer(16'hFFFF, 16'h0000, 1'b0);
        run_xfer(16'h0000, 16'hFFFF, 1'b0);
        run_xfer(16'h8001, 16'h1234, 1'b1);

        // R7: start held high -> immediate restart once idle
        resp = 16'hBEEF;
        @(negedge clk); start_i = 1'b1; operand_i = 16'h6C19;
        wait_done(seen);
        check(result_o == 16'hBEEF, "R7 first of held start", 32'(result_o), 32'hBEEF);
        resp = 16'h5A0F;
        operand_i = 16'h0F3E;
        @(negedge clk);
        @(negedge clk);
        check(busy_o == 1'b0, "R7 one idle cycle between", 32'(busy_o), 32'd0);
        @(negedge clk);
        check(busy_o == 1'b1, "R7 restart on idle cycle", 32'(busy_o), 32'd1);
        start_i = 1'b0;
        wait_done(seen);
        check(result_o == 16'h5A0F, "R7 second of held start", 32'(result_o), 32'h5A0F);
        repeat (5) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule